// File: doc/BRIEF.md
# Boot Console Register Window

This block is a slave register window that boot firmware and an early kernel share. It holds a few fixed 32-bit identity words and a set of 64-bit boot descriptors; most of these come from input ports wired to whatever loads the boot image. It also holds writable disk-transfer parameters, a one-byte character output port, a pulled character input port, and a table of per-CPU start stacks.

A host drives one request per cycle on a plain address/size/read/write bus. Every request gets a response one cycle later that carries an OK flag and read data. Writing the disk-read command code launches a single-cycle request to an external disk engine, and the block stays busy until that engine signals completion. Character output leaves as a byte with a valid strobe. Character input is taken from an external byte source, which is told to advance whenever its byte is consumed.

Top module: `boot_console_regs`

## Requirements
- R1: A 4-byte read at offset 0x00 returns 0x26F (window size minus one), at 0x04 returns 1305, at 0x08 the CPU count input, at 0x0C the interrupt clock frequency input, all zero-extended; a 4-byte read at any other offset is answered not-OK with data 0.
- R2: 8-byte reads at 0x10, 0x18, 0x20, 0x28 and 0x30 return the CPU clock (MHz), memory size, kernel start, kernel end and entry point inputs; 8-byte accesses at offsets below 0x10 or not a multiple of 8 are answered not-OK.
- R3: After reset, the disk unit (0x38) reads 1 and the following read 0: disk count (0x40), disk address (0x48), disk block (0x50), disk operation (0x58), output char (0x60) and every stack entry. rsp_valid, tx_valid and dsk_req are low.
- R4: Writes are accepted only as 8-byte accesses to 0x38, 0x40, 0x48, 0x50, 0x58, 0x60 or the stack table. Any other write, including a 4-byte write or a write to a read-only 8-byte register, is answered not-OK and changes no state.
- R5: An accepted write to 0x60 raises tx_valid for exactly one cycle, in the response cycle, with tx_byte equal to bits 7:0 of the written data. A later 8-byte read of 0x60 returns that byte zero-extended.
- R6: An 8-byte read of 0x68 returns the current rx_byte zero-extended and raises rx_pull in the request cycle. No other access raises rx_pull.
- R7: Writing 0x13 to 0x58 while not busy is answered OK. In the response cycle it produces a one-cycle dsk_req, with dsk_paddr, dsk_block and dsk_count equal to the stored values of 0x48, 0x50 and 0x40. Any other value is answered not-OK and produces no request.
- R8: After a launch the block is busy until a cycle with dsk_done high. A write to 0x58 while busy is answered not-OK and produces no request. After dsk_done a new launch is accepted.
- R9: Stack entry n sits at offset 0x70 + 8n, for n from 0 to 63. A nonzero 8-byte write stores the value, and a read returns it. A zero write is answered not-OK and leaves the entry unchanged.
- R10: A request with a size other than 4 or 8, or with an offset of 0x270 or above, is answered not-OK with data 0 and changes no state.
- R11: Every cycle with req_valid high is followed by exactly one cycle with rsp_valid high, and rsp_valid is low after a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset within the window |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_ok | output | 1 | 1 = accepted, 0 = bad address or rejected |
| rsp_rdata | output | 64 | Read data, 0 for writes and errors |
| cfg_cpu_count | input | 32 | CPU count word |
| cfg_irq_hz | input | 32 | Interrupt clock frequency in Hz |
| cfg_cpu_mhz | input | 64 | CPU clock in MHz |
| cfg_mem_size | input | 64 | Memory size |
| cfg_kern_lo | input | 64 | Kernel start address |
| cfg_kern_hi | input | 64 | Kernel end address |
| cfg_entry | input | 64 | Kernel entry point |
| dsk_req | output | 1 | One-cycle disk read request |
| dsk_paddr | output | 64 | Stored disk target address |
| dsk_block | output | 64 | Stored disk block number |
| dsk_count | output | 64 | Stored disk block count |
| dsk_done | input | 1 | Disk engine completion |
| tx_valid | output | 1 | Output character strobe |
| tx_byte | output | 8 | Output character |
| rx_byte | input | 8 | Head byte of the input source |
| rx_pull | output | 1 | Input byte consumed this cycle |

## Verification
The hardest case to reach is a launch attempt while a disk transfer is still outstanding. The stimulus gets there by loading the disk parameters, launching, and then writing the command again before dsk_done is driven. It checks that the second write is rejected with no pulse, then drives dsk_done and shows that a relaunch carries the parameters that were rewritten in between. The rejected cases are confirmed at the ports: zero stack writes, wrong command codes and writes to read-only offsets are each followed by a read-back that shows the stored value unchanged.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  typedef enum logic [4:0] {
    S_NONE, S_LASTOFF, S_VER, S_NCPU, S_IRQ,
    S_CLK, S_MEM, S_KLO, S_KHI, S_ENTRY,
    S_DUNIT, S_DCNT, S_DADDR, S_DBLK, S_DOP,
    S_OUT, S_IN, S_STACK
  } sel_e;

  localparam int unsigned WIDE_BASE  = 'h10;
  localparam int unsigned STACK_BASE = 'h70;
  localparam logic [63:0] DISK_READ_CMD = 64'h13;
endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
  import bcr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned NUM_STACK = 64,
  localparam int unsigned IDX_W    = $clog2(NUM_STACK)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  input  logic              write,
  output sel_e              sel,
  output logic [IDX_W-1:0]  stk_idx,
  output logic              legal
);
  localparam logic [ADDR_W-1:0] REGION = ADDR_W'(STACK_BASE + 8 * NUM_STACK);
  localparam logic [ADDR_W-1:0] WBASE  = ADDR_W'(WIDE_BASE);
  localparam logic [ADDR_W-1:0] SBASE  = ADDR_W'(STACK_BASE);

  logic [ADDR_W-1:0] woff;
  logic [ADDR_W-1:0] sidx_full;
  logic              writable;
  logic              unused_bits;

  assign woff        = addr - WBASE;
  assign sidx_full   = (addr - SBASE) >> 3;
  assign unused_bits = ^{woff, sidx_full};

  always_comb begin
    sel     = S_NONE;
    stk_idx = sidx_full[IDX_W-1:0];
    if (addr < REGION) begin
      if (size == 4'd4) begin
        case (addr)
          ADDR_W'('h00): sel = S_LASTOFF;
          ADDR_W'('h04): sel = S_VER;
          ADDR_W'('h08): sel = S_NCPU;
          ADDR_W'('h0C): sel = S_IRQ;
          default:       sel = S_NONE;
        endcase
      end else if (size == 4'd8 && addr[2:0] == 3'd0 && addr >= WBASE) begin
        if (addr >= SBASE) begin
          sel = S_STACK;
        end else begin
          case (woff[6:3])
            4'd0:    sel = S_CLK;
            4'd1:    sel = S_MEM;
            4'd2:    sel = S_KLO;
            4'd3:    sel = S_KHI;
            4'd4:    sel = S_ENTRY;
            4'd5:    sel = S_DUNIT;
            4'd6:    sel = S_DCNT;
            4'd7:    sel = S_DADDR;
            4'd8:    sel = S_DBLK;
            4'd9:    sel = S_DOP;
            4'd10:   sel = S_OUT;
            4'd11:   sel = S_IN;
            default: sel = S_NONE;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (sel)
      S_DUNIT, S_DCNT, S_DADDR, S_DBLK, S_DOP, S_OUT, S_STACK: writable = 1'b1;
      default: writable = 1'b0;
    endcase
    legal = (sel != S_NONE) && (!write || writable);
  end
endmodule

// File: rtl/bcr_stack_table.sv
module bcr_stack_table #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[widx] <= wdata;
    end
  end

  assign rdata = mem_q[ridx];
endmodule

// File: rtl/bcr_disk_ctl.sv
module bcr_disk_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic done,
  output logic busy,
  output logic req
);
  logic busy_q, busy_d;
  logic req_q;

  always_comb begin
    busy_d = busy_q;
    if (launch)    busy_d = 1'b1;
    else if (done) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      req_q  <= launch;
    end
  end

  assign busy = busy_q;
  assign req  = req_q;
endmodule

// File: rtl/boot_console_regs.sv
module boot_console_regs
  import bcr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned NUM_STACK = 64,
  parameter int unsigned VERSION   = 1305
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [63:0]       rsp_rdata,
  input  logic [31:0]       cfg_cpu_count,
  input  logic [31:0]       cfg_irq_hz,
  input  logic [63:0]       cfg_cpu_mhz,
  input  logic [63:0]       cfg_mem_size,
  input  logic [63:0]       cfg_kern_lo,
  input  logic [63:0]       cfg_kern_hi,
  input  logic [63:0]       cfg_entry,
  output logic              dsk_req,
  output logic [63:0]       dsk_paddr,
  output logic [63:0]       dsk_block,
  output logic [63:0]       dsk_count,
  input  logic              dsk_done,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic [7:0]        rx_byte,
  output logic              rx_pull
);
  localparam int unsigned IDX_W    = $clog2(NUM_STACK);
  localparam logic [31:0] LAST_OFF = 32'(STACK_BASE + 8 * NUM_STACK - 1);
  localparam logic [31:0] VER_WORD = 32'(VERSION);

  sel_e             sel;
  logic [IDX_W-1:0] stk_idx;
  logic             legal, sem_ok, wr_en, launch, busy;
  logic [63:0]      stk_rdata, rd_mux;

  logic [63:0] dunit_q, dcnt_q, daddr_q, dblk_q, dop_q;
  logic [63:0] dunit_d, dcnt_d, daddr_d, dblk_d, dop_d;
  logic        rsp_valid_q, rsp_ok_q, tx_valid_q;
  logic [63:0] rsp_rdata_q, rsp_rdata_d;
  logic [7:0]  tx_byte_q, tx_byte_d;

  bcr_decode #(.ADDR_W(ADDR_W), .NUM_STACK(NUM_STACK)) u_dec (
    .addr(req_addr), .size(req_size), .write(req_write),
    .sel(sel), .stk_idx(stk_idx), .legal(legal)
  );

  always_comb begin
    sem_ok = 1'b1;
    if (req_write) begin
      if (sel == S_DOP)   sem_ok = (req_wdata == DISK_READ_CMD) && !busy;
      if (sel == S_STACK) sem_ok = (req_wdata != 64'd0);
    end
  end

  assign wr_en   = req_valid && req_write && legal && sem_ok;
  assign launch  = wr_en && (sel == S_DOP);
  assign rx_pull = req_valid && !req_write && legal && (sel == S_IN);

  bcr_stack_table #(.DEPTH(NUM_STACK), .DW(64)) u_stk (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en && (sel == S_STACK)), .widx(stk_idx), .wdata(req_wdata),
    .ridx(stk_idx), .rdata(stk_rdata)
  );

  bcr_disk_ctl u_dsk (
    .clk(clk), .rst_n(rst_n), .launch(launch), .done(dsk_done),
    .busy(busy), .req(dsk_req)
  );

  always_comb begin
    case (sel)
      S_LASTOFF: rd_mux = {32'd0, LAST_OFF};
      S_VER:     rd_mux = {32'd0, VER_WORD};
      S_NCPU:    rd_mux = {32'd0, cfg_cpu_count};
      S_IRQ:     rd_mux = {32'd0, cfg_irq_hz};
      S_CLK:     rd_mux = cfg_cpu_mhz;
      S_MEM:     rd_mux = cfg_mem_size;
      S_KLO:     rd_mux = cfg_kern_lo;
      S_KHI:     rd_mux = cfg_kern_hi;
      S_ENTRY:   rd_mux = cfg_entry;
      S_DUNIT:   rd_mux = dunit_q;
      S_DCNT:    rd_mux = dcnt_q;
      S_DADDR:   rd_mux = daddr_q;
      S_DBLK:    rd_mux = dblk_q;
      S_DOP:     rd_mux = dop_q;
      S_OUT:     rd_mux = {56'd0, tx_byte_q};
      S_IN:      rd_mux = {56'd0, rx_byte};
      S_STACK:   rd_mux = stk_rdata;
      default:   rd_mux = 64'd0;
    endcase
  end

  always_comb begin
    dunit_d   = dunit_q;
    dcnt_d    = dcnt_q;
    daddr_d   = daddr_q;
    dblk_d    = dblk_q;
    dop_d     = dop_q;
    tx_byte_d = tx_byte_q;
    if (wr_en) begin
      case (sel)
        S_DUNIT: dunit_d   = req_wdata;
        S_DCNT:  dcnt_d    = req_wdata;
        S_DADDR: daddr_d   = req_wdata;
        S_DBLK:  dblk_d    = req_wdata;
        S_DOP:   dop_d     = req_wdata;
        S_OUT:   tx_byte_d = req_wdata[7:0];
        default: ;
      endcase
    end
    rsp_rdata_d = (req_valid && !req_write && legal) ? rd_mux : 64'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dunit_q     <= 64'd1;
      dcnt_q      <= '0;
      daddr_q     <= '0;
      dblk_q      <= '0;
      dop_q       <= '0;
      tx_byte_q   <= '0;
      tx_valid_q  <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_ok_q    <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      dunit_q     <= dunit_d;
      dcnt_q      <= dcnt_d;
      daddr_q     <= daddr_d;
      dblk_q      <= dblk_d;
      dop_q       <= dop_d;
      tx_byte_q   <= tx_byte_d;
      tx_valid_q  <= wr_en && (sel == S_OUT);
      rsp_valid_q <= req_valid;
      rsp_ok_q    <= req_valid && legal && sem_ok;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_ok    = rsp_ok_q;
  assign rsp_rdata = rsp_rdata_q;
  assign tx_valid  = tx_valid_q;
  assign tx_byte   = tx_byte_q;
  assign dsk_paddr = daddr_q;
  assign dsk_block = dblk_q;
  assign dsk_count = dcnt_q;
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_size,
  input logic [63:0]       req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic              tx_valid,
  input logic [7:0]        tx_byte,
  input logic              dsk_req,
  input logic              dsk_done,
  input logic              rx_pull
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q | dsk_req) & ~dsk_done;
  end

  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r10_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 4'd4 && req_size != 4'd8) |=> !rsp_ok);
  a_r5_tx_source: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(req_valid && req_write && req_size == 4'd8 &&
                       req_addr == ADDR_W'('h60)));
  a_r5_tx_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_byte == $past(req_wdata[7:0]));
  a_r7_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_req |=> !dsk_req);
  a_r8_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_req |-> !pend_q);
  a_r6_pull_read: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pull |-> (req_valid && !req_write && req_addr == ADDR_W'('h68)));
endmodule

bind boot_console_regs bcr_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_boot_console_regs.sv
module sim_boot_console_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, dsk_done;
  logic [9:0]  req_addr;
  logic [3:0]  req_size;
  logic [63:0] req_wdata;
  logic        rsp_valid, rsp_ok, dsk_req, tx_valid, rx_pull;
  logic [63:0] rsp_rdata, dsk_paddr, dsk_block, dsk_count;
  logic [7:0]  tx_byte, rx_byte;

  localparam logic [31:0] C_NCPU = 32'd4;
  localparam logic [31:0] C_IRQ  = 32'd1024;
  localparam logic [63:0] C_MHZ  = 64'd2000;
  localparam logic [63:0] C_MEM  = 64'h8000_0000;
  localparam logic [63:0] C_KLO  = 64'h0000_0000_0031_0000;
  localparam logic [63:0] C_KHI  = 64'h0000_0000_0088_4000;
  localparam logic [63:0] C_ENT  = 64'hFFFF_FC00_0031_0000;

  always #2 clk = ~clk;

  boot_console_regs u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata),
    .cfg_cpu_count(C_NCPU), .cfg_irq_hz(C_IRQ), .cfg_cpu_mhz(C_MHZ),
    .cfg_mem_size(C_MEM), .cfg_kern_lo(C_KLO), .cfg_kern_hi(C_KHI),
    .cfg_entry(C_ENT), .dsk_req(dsk_req), .dsk_paddr(dsk_paddr),
    .dsk_block(dsk_block), .dsk_count(dsk_count), .dsk_done(dsk_done),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_pull(rx_pull)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model state
  logic [63:0] m_unit, m_cnt, m_addr, m_blk, m_op;
  logic [7:0]  m_out;
  logic [63:0] m_stk [64];
  bit          m_busy;
  byte unsigned rx_q[$];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input bit w, input int a, input int s, input logic [63:0] d,
                       output bit ok, output logic [63:0] rd, output bit txv,
                       output bit dreq, output bit pull);
    ok = 0; rd = 0; txv = 0; dreq = 0; pull = 0;
    if (s == 4 && !w) begin
      ok = 1;
      case (a)
        'h00: rd = 64'h26F;
        'h04: rd = 64'd1305;
        'h08: rd = {32'd0, C_NCPU};
        'h0C: rd = {32'd0, C_IRQ};
        default: ok = 0;
      endcase
    end else if (s == 8 && a % 8 == 0 && a >= 'h10 && a < 'h270) begin
      if (a >= 'h70) begin
        int idx = (a - 'h70) / 8;
        if (!w) begin ok = 1; rd = m_stk[idx]; end
        else if (d != 0) begin ok = 1; m_stk[idx] = d; end
      end else begin
        case (a)
          'h10: if (!w) begin ok = 1; rd = C_MHZ; end
          'h18: if (!w) begin ok = 1; rd = C_MEM; end
          'h20: if (!w) begin ok = 1; rd = C_KLO; end
          'h28: if (!w) begin ok = 1; rd = C_KHI; end
          'h30: if (!w) begin ok = 1; rd = C_ENT; end
          'h38: begin ok = 1; if (w) m_unit = d; else rd = m_unit; end
          'h40: begin ok = 1; if (w) m_cnt  = d; else rd = m_cnt;  end
          'h48: begin ok = 1; if (w) m_addr = d; else rd = m_addr; end
          'h50: begin ok = 1; if (w) m_blk  = d; else rd = m_blk;  end
          'h58: if (!w) begin ok = 1; rd = m_op; end
                else if (d == 64'h13 && !m_busy) begin
                  ok = 1; dreq = 1; m_op = d; m_busy = 1;
                end
          'h60: begin ok = 1; if (w) begin txv = 1; m_out = d[7:0]; end
                      else rd = {56'd0, m_out}; end
          'h68: if (!w) begin ok = 1; pull = 1; rd = {56'd0, rx_byte}; end
          default: ;
        endcase
      end
    end
  endtask

  // one clock with optional request; every output compared afterwards
  task automatic step(input string tag, input bit v, input bit w, input int a,
                      input int s, input logic [63:0] d, input bit done);
    bit ok, txv, dreq, pull;
    logic [63:0] rd;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = 10'(a); req_size = 4'(s);
    req_wdata = d; dsk_done = done;
    ok = 0; rd = 0; txv = 0; dreq = 0; pull = 0;
    if (v) model(w, a, s, d, ok, rd, txv, dreq, pull);
    if (done && !dreq) m_busy = 0;
    #1 chk({tag, " rx_pull (R6)"}, {63'd0, rx_pull}, {63'd0, pull});
    @(posedge clk);
    #1;
    chk({tag, " rsp_valid (R11)"}, {63'd0, rsp_valid}, {63'd0, v});
    if (v) begin
      chk({tag, " rsp_ok"}, {63'd0, rsp_ok}, {63'd0, ok});
      chk({tag, " rsp_rdata"}, rsp_rdata, rd);
    end
    chk({tag, " tx_valid (R5)"}, {63'd0, tx_valid}, {63'd0, txv});
    if (txv) chk({tag, " tx_byte (R5)"}, {56'd0, tx_byte}, {56'd0, m_out});
    chk({tag, " dsk_req (R7)"}, {63'd0, dsk_req}, {63'd0, dreq});
    if (dreq) begin
      chk({tag, " dsk_paddr (R7)"}, dsk_paddr, m_addr);
      chk({tag, " dsk_block (R7)"}, dsk_block, m_blk);
      chk({tag, " dsk_count (R7)"}, dsk_count, m_cnt);
    end
    if (pull) begin
      void'(rx_q.pop_front());
      rx_byte = (rx_q.size() > 0) ? rx_q[0] : 8'h00;
    end
    req_valid = 0; dsk_done = 0;
  endtask

  task automatic rd8(string tag, int a); step(tag, 1, 0, a, 8, 64'd0, 0); endtask
  task automatic rd4(string tag, int a); step(tag, 1, 0, a, 4, 64'd0, 0); endtask
  task automatic wr8(string tag, int a, logic [63:0] d); step(tag, 1, 1, a, 8, d, 0); endtask
  task automatic idle(string tag, bit done); step(tag, 0, 0, 0, 8, 64'd0, done); endtask

  initial begin
    #150000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_size = 0;
    req_wdata = 0; dsk_done = 0;
    m_unit = 1; m_cnt = 0; m_addr = 0; m_blk = 0; m_op = 0; m_out = 0; m_busy = 0;
    for (int i = 0; i < 64; i++) m_stk[i] = 0;
    rx_q = '{8'h41, 8'h0D, 8'hFF};
    rx_byte = rx_q[0];
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R3 reset state
    chk("R3 rsp_valid at reset", {63'd0, rsp_valid}, 64'd0);
    chk("R3 tx_valid at reset", {63'd0, tx_valid}, 64'd0);
    chk("R3 dsk_req at reset", {63'd0, dsk_req}, 64'd0);
    rd8("R3 disk unit", 'h38);
    rd8("R3 disk count", 'h40);
    rd8("R3 disk addr", 'h48);
    rd8("R3 disk block", 'h50);
    rd8("R3 disk op", 'h58);
    rd8("R3 out char", 'h60);
    rd8("R3 stack 5", 'h70 + 8 * 5);

    // R1 32-bit words
    rd4("R1 last offset", 'h00);
    rd4("R1 version", 'h04);
    rd4("R1 cpu count", 'h08);
    rd4("R1 irq hz", 'h0C);
    rd4("R1 bad 32-bit at 0x10", 'h10);
    rd4("R1 bad 32-bit at 0x02", 'h02);

    // R2 64-bit descriptors
    for (int a = 'h10; a <= 'h30; a += 8) rd8("R2 descriptor", a);
    rd8("R2 bad 64-bit at 0x00", 'h00);
    rd8("R2 bad 64-bit at 0x08", 'h08);
    rd8("R2 unaligned 0x14", 'h14);

    // R4 illegal writes, R10 illegal size / range
    step("R4 4-byte write", 1, 1, 'h38, 4, 64'h55, 0);
    wr8("R4 write read-only 0x10", 'h10, 64'h99);
    wr8("R4 write input char", 'h68, 64'h99);
    step("R4 write 32-bit word", 1, 1, 'h04, 4, 64'h7, 0);
    rd8("R4 disk unit unchanged", 'h38);
    rd8("R4 cpu clock unchanged", 'h10);
    step("R10 size 2", 1, 0, 'h00, 2, 64'd0, 0);
    step("R10 size 2 write", 1, 1, 'h38, 2, 64'h77, 0);
    rd8("R10 at 0x270", 'h270);
    wr8("R10 write 0x3F8", 'h3F8, 64'h5);
    rd8("R10 disk unit unchanged", 'h38);
    idle("R11 idle", 0);

    // R7/R8 disk launch
    wr8("R7 set unit", 'h38, 64'd2);
    wr8("R7 set count", 'h40, 64'd8);
    wr8("R7 set addr", 'h48, 64'h0000_0000_0020_0000);
    wr8("R7 set block", 'h50, 64'd17);
    wr8("R7 bad command", 'h58, 64'h12);
    rd8("R7 op unchanged", 'h58);
    wr8("R7 launch", 'h58, 64'h13);
    wr8("R8 launch while busy", 'h58, 64'h13);
    wr8("R8 change block while busy", 'h50, 64'd40);
    idle("R8 idle busy", 0);
    wr8("R8 still busy", 'h58, 64'h13);
    idle("R8 done", 1);
    wr8("R8 relaunch", 'h58, 64'h13);
    idle("R8 done again", 1);
    rd8("R7 op readback", 'h58);

    // R5 output char
    wr8("R5 emit", 'h60, 64'h1234_5678_9ABC_DEA5);
    idle("R5 strobe one cycle", 0);
    rd8("R5 readback", 'h60);
    wr8("R5 emit back to back", 'h60, 64'h0A);
    wr8("R5 emit back to back 2", 'h60, 64'hFF00);

    // R6 input char
    rd8("R6 first char", 'h68);
    rd8("R6 second char", 'h68);
    rd4("R6 no pull on 32-bit", 'h0C);
    rd8("R6 third char", 'h68);

    // R9 stack table
    wr8("R9 write entry 0", 'h70, 64'hDEAD_0000_0000_0001);
    wr8("R9 write entry 63", 'h70 + 8 * 63, 64'hCAFE_0000_0000_003F);
    wr8("R9 write entry 3", 'h70 + 8 * 3, 64'h33);
    wr8("R9 zero write entry 3", 'h70 + 8 * 3, 64'd0);
    rd8("R9 read entry 0", 'h70);
    rd8("R9 read entry 63", 'h70 + 8 * 63);
    rd8("R9 read entry 3", 'h70 + 8 * 3);
    rd8("R9 read entry 1", 'h78);
    idle("R11 final idle", 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule